// File: doc/BRIEF.md
# Speculative Load Retirement Queue

This block keeps an in-order record of loads that a core has issued ahead of older memory operations. When a load is dispatched it takes the next slot of a circular queue, in memory program order, and receives a slot index. When its speculative data comes back, the pipeline reports the address and access size against that index. From then on the slot holds a marker whose validity drops, for good, as soon as something shows that the early value may be stale.

Two kinds of event can spoil a marker. The first is an older local store whose address resolves late and overlaps the load. The second is the loss of the cache line that holds the load's data, whether by eviction or by a snoop from another agent. The queue's head moves forward on its own, one load per cycle, separately from instruction retirement. A head load with an intact marker retires quietly. A head load with a spoiled marker raises a replay and a violation report that carries its PC. The queue then discards that load and every younger one so that the pipeline can re-execute them in order. No barrier instruction is needed for ordering: every early load is checked at the point where it leaves the queue.

Top module: `spec_load_rq`

## Requirements
- R1: Each accepted dispatch (`alloc_valid` high while `alloc_ready` is high) takes slot `alloc_idx`, and the following slot index is one higher, wrapping from DEPTH-1 to 0. `alloc_ready` is low while DEPTH loads are held.
- R2: The head load leaves the queue in the cycle after the clock edge at which it is both allocated and reported done. Loads leave strictly in dispatch order, even when a younger load's data came back first.
- R3: A store with `st_bound` at or before a done load's position, counted from the head in dispatch order, is older than that load. Such a store spoils the load's marker when their naturally aligned regions intersect. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Two regions intersect when both addresses agree above the larger access's size.
- R4: A store whose `st_bound` lies after a load's position is younger than that load and leaves its marker intact.
- R5: A line-loss event spoils every done marker whose address, shifted right by LINE_BITS (64-byte lines by default), equals `snp_line`. Markers on other lines are untouched.
- R6: A spoiled marker stays spoiled until its load leaves the queue. Later quiet cycles and the head's other activity do not restore it.
- R7: A load that leaves with a spoiled marker pulses `ret_replay` and `viol_valid` together, with `ret_pc` and `viol_pc` both equal to its PC. A load with an intact marker pulses `ret_ok` with `ret_pc` set and no violation.
- R8: A store or line-loss event that hits the head load in the same cycle as its retirement wins, and that load is replayed.
- R9: A replay empties the queue. In the next cycle `alloc_ready` is high, `alloc_idx` equals the replayed load's slot, and DEPTH new loads are accepted.
- R10: After synchronous reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `ret_ok`, `ret_replay` and `viol_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch of a load in program order |
| alloc_pc | input | PC_W | PC of the dispatched load |
| alloc_ready | output | 1 | Queue can accept a dispatch this cycle |
| alloc_idx | output | IDX_W | Slot the next dispatch will take |
| done_valid | input | 1 | Speculative data returned for a slot |
| done_idx | input | IDX_W | Slot whose data returned |
| done_addr | input | ADDR_W | Byte address the load read |
| done_size | input | 2 | Access size code of the load |
| st_valid | input | 1 | A local store address resolved |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_bound | input | IDX_W | First slot younger than the store |
| snp_valid | input | 1 | A cache line was evicted or taken by another agent |
| snp_line | input | ADDR_W-LINE_BITS | Line address that was lost |
| ret_ok | output | 1 | Head load left with an intact marker |
| ret_replay | output | 1 | Head load left with a spoiled marker; queue flushed |
| ret_pc | output | PC_W | PC of the load that left |
| viol_valid | output | 1 | Ordering violation report |
| viol_pc | output | PC_W | PC of the violating load, for predictor training |

## Verification
The checker assumes that `done_idx` only names a slot that has been allocated and not yet reported done. It also assumes that `st_bound` lies between the head and the tail, and that no store or line-loss event arrives in the same cycle as the done report it would affect. The bench builds every scenario from an empty queue. It takes slot numbers from `alloc_idx`, reports done only for slots it has just allocated, and always separates a done report from the event that tests it by at least one edge. The one exception is the head-priority case, where the event lands on the retirement edge on purpose.

// File: rtl/spec_load_rq_pkg.sv
package spec_load_rq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int unsigned MAX_ADDR_W = 64;

    // Naturally aligned regions intersect when both addresses agree above
    // the larger of the two access sizes.
    function automatic logic regions_overlap(
        input logic [MAX_ADDR_W-1:0] a_addr,
        input logic [1:0]            a_size,
        input logic [MAX_ADDR_W-1:0] b_addr,
        input logic [1:0]            b_size
    );
        logic [1:0]            big;
        logic [MAX_ADDR_W-1:0] keep;
        big  = (a_size > b_size) ? a_size : b_size;
        keep = ~((MAX_ADDR_W'(1) << big) - MAX_ADDR_W'(1));
        return (a_addr & keep) == (b_addr & keep);
    endfunction

    // Distance of a slot from the head in a circular queue of any depth.
    function automatic int unsigned slot_age(
        input int unsigned slot,
        input int unsigned head,
        input int unsigned depth
    );
        return (slot >= head) ? (slot - head) : (slot + depth - head);
    endfunction

    typedef enum logic [1:0] {
        HEAD_IDLE   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_REPLAY = 2'd2
    } head_action_e;

endpackage

// File: rtl/slrq_ptrs.sv
module slrq_ptrs #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [CNT_W-1:0] count;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            if (pop)  head <= step(head);
            if (push) tail <= step(tail);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/slrq_entry.sv
module slrq_entry
    import spec_load_rq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned LINE_BITS = 6,
    parameter int unsigned MY_SLOT   = 0,
    localparam int unsigned IDX_W    = $clog2(DEPTH),
    localparam int unsigned LINE_W   = ADDR_W - LINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              done_en,
    input  logic [ADDR_W-1:0] done_addr,
    input  logic [1:0]        done_size,
    input  logic              clear_en,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [IDX_W-1:0]  st_bound,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    output logic              busy,
    output logic              done,
    output logic              intact,
    output logic              kill,
    output logic [PC_W-1:0]   pc
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              intact;
        logic [PC_W-1:0]   pc;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
    } marker_t;

    marker_t m;
    logic    younger_than_store;
    logic    st_hit;
    logic    snp_hit;

    always_comb begin
        younger_than_store = slot_age(MY_SLOT, 32'(head_idx), DEPTH)
                             >= slot_age(32'(st_bound), 32'(head_idx), DEPTH);
        st_hit  = st_valid && younger_than_store &&
                  regions_overlap(MAX_ADDR_W'(m.addr), m.size,
                                  MAX_ADDR_W'(st_addr), st_size);
        snp_hit = snp_valid && (m.addr[ADDR_W-1:LINE_BITS] == snp_line);
        kill    = m.busy && m.done && (st_hit || snp_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_en) begin
            m <= '0;
        end else if (alloc_en) begin
            m.busy   <= 1'b1;
            m.done   <= 1'b0;
            m.intact <= 1'b1;
            m.pc     <= alloc_pc;
            m.addr   <= '0;
            m.size   <= '0;
        end else begin
            if (done_en) begin
                m.done <= 1'b1;
                m.addr <= done_addr;
                m.size <= done_size;
            end
            // validity can only fall; nothing restores it
            if (kill) m.intact <= 1'b0;
        end
    end

    assign busy   = m.busy;
    assign done   = m.done;
    assign intact = m.intact;
    assign pc     = m.pc;
endmodule

// File: rtl/slrq_retire.sv
module slrq_retire
    import spec_load_rq_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            head_busy,
    input  logic            head_done,
    input  logic            head_intact,
    input  logic            head_kill,
    input  logic [PC_W-1:0] head_pc,
    output logic            pop,
    output logic            flush,
    output logic            ret_ok,
    output logic            ret_replay,
    output logic [PC_W-1:0] ret_pc,
    output logic            viol_valid,
    output logic [PC_W-1:0] viol_pc
);
    head_action_e act;

    always_comb begin
        act = HEAD_IDLE;
        if (head_busy && head_done)
            act = (head_intact && !head_kill) ? HEAD_RETIRE : HEAD_REPLAY;
    end

    assign pop   = (act == HEAD_RETIRE);
    assign flush = (act == HEAD_REPLAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_ok     <= 1'b0;
            ret_replay <= 1'b0;
            ret_pc     <= '0;
            viol_valid <= 1'b0;
            viol_pc    <= '0;
        end else begin
            ret_ok     <= pop;
            ret_replay <= flush;
            viol_valid <= flush;
            if (act != HEAD_IDLE) ret_pc  <= head_pc;
            if (flush)            viol_pc <= head_pc;
        end
    end
endmodule

// File: rtl/spec_load_rq.sv
module spec_load_rq
    import spec_load_rq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned LINE_BITS = 6,
    localparam int unsigned IDX_W    = $clog2(DEPTH),
    localparam int unsigned LINE_W   = ADDR_W - LINE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic [ADDR_W-1:0] done_addr,
    input  logic [1:0]        done_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [IDX_W-1:0]  st_bound,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    output logic              ret_ok,
    output logic              ret_replay,
    output logic [PC_W-1:0]   ret_pc,
    output logic              viol_valid,
    output logic [PC_W-1:0]   viol_pc
);
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic             full;
    logic             push;
    logic             pop;
    logic             flush;

    logic [DEPTH-1:0] e_busy;
    logic [DEPTH-1:0] e_done;
    logic [DEPTH-1:0] e_intact;
    logic [DEPTH-1:0] e_kill;
    logic [PC_W-1:0]  e_pc [DEPTH];

    assign alloc_ready = !full && !flush;
    assign push        = alloc_valid && alloc_ready;
    assign alloc_idx   = tail;

    slrq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .head  (head),
        .tail  (tail),
        .full  (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic alloc_here;
        logic done_here;
        logic clear_here;
        assign alloc_here = push && (tail == IDX_W'(g));
        assign done_here  = done_valid && (done_idx == IDX_W'(g));
        assign clear_here = flush || (pop && (head == IDX_W'(g)));

        slrq_entry #(
            .DEPTH     (DEPTH),
            .ADDR_W    (ADDR_W),
            .PC_W      (PC_W),
            .LINE_BITS (LINE_BITS),
            .MY_SLOT   (g)
        ) u_entry (
            .clk       (clk),
            .rst       (rst),
            .alloc_en  (alloc_here),
            .alloc_pc  (alloc_pc),
            .done_en   (done_here),
            .done_addr (done_addr),
            .done_size (done_size),
            .clear_en  (clear_here),
            .head_idx  (head),
            .st_valid  (st_valid),
            .st_addr   (st_addr),
            .st_size   (st_size),
            .st_bound  (st_bound),
            .snp_valid (snp_valid),
            .snp_line  (snp_line),
            .busy      (e_busy[g]),
            .done      (e_done[g]),
            .intact    (e_intact[g]),
            .kill      (e_kill[g]),
            .pc        (e_pc[g])
        );
    end

    slrq_retire #(.PC_W(PC_W)) u_retire (
        .clk         (clk),
        .rst         (rst),
        .head_busy   (e_busy[head]),
        .head_done   (e_done[head]),
        .head_intact (e_intact[head]),
        .head_kill   (e_kill[head]),
        .head_pc     (e_pc[head]),
        .pop         (pop),
        .flush       (flush),
        .ret_ok      (ret_ok),
        .ret_replay  (ret_replay),
        .ret_pc      (ret_pc),
        .viol_valid  (viol_valid),
        .viol_pc     (viol_pc)
    );
endmodule

// File: rtl/spec_load_rq_checker.sv
module spec_load_rq_checker #(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned LINE_BITS = 6,
    localparam int unsigned IDX_W    = $clog2(DEPTH),
    localparam int unsigned LINE_W   = ADDR_W - LINE_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic [PC_W-1:0]   alloc_pc,
    input logic              alloc_ready,
    input logic [IDX_W-1:0]  alloc_idx,
    input logic              done_valid,
    input logic [IDX_W-1:0]  done_idx,
    input logic [ADDR_W-1:0] done_addr,
    input logic [1:0]        done_size,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic [1:0]        st_size,
    input logic [IDX_W-1:0]  st_bound,
    input logic              snp_valid,
    input logic [LINE_W-1:0] snp_line,
    input logic              ret_ok,
    input logic              ret_replay,
    input logic [PC_W-1:0]   ret_pc,
    input logic              viol_valid,
    input logic [PC_W-1:0]   viol_pc
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_after;
    assign idx_after = (alloc_idx == LAST) ? '0 : alloc_idx + 1'b1;

    // R1: an accepted dispatch moves the next slot on by one, with wrap
    a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> (alloc_idx == $past(idx_after)));

    // R2: a retirement is either quiet or a replay, never both
    a_r2_single_outcome: assert property (@(posedge clk) disable iff (rst)
        !(ret_ok && ret_replay));

    // R7: a replay carries a violation report for the same load
    a_r7_viol_with_replay: assert property (@(posedge clk) disable iff (rst)
        ret_replay |-> (viol_valid && (viol_pc == ret_pc)));

    // R7: no violation report without a replay
    a_r7_no_stray_viol: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> ret_replay);

    // R9: after a replay the emptied queue accepts a dispatch
    a_r9_ready_after_flush: assert property (@(posedge clk) disable iff (rst)
        ret_replay |-> alloc_ready);
endmodule

bind spec_load_rq spec_load_rq_checker #(
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .PC_W      (PC_W),
    .LINE_BITS (LINE_BITS)
) u_checker (.*);

// File: tb/spec_load_rq_bench.sv
module spec_load_rq_bench;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned PC_W   = 32;
    localparam int unsigned LB     = 6;
    localparam int unsigned IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic [PC_W-1:0]   alloc_pc = '0;
    logic              alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              done_valid = 1'b0;
    logic [IDX_W-1:0]  done_idx = '0;
    logic [ADDR_W-1:0] done_addr = '0;
    logic [1:0]        done_size = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic [IDX_W-1:0]  st_bound = '0;
    logic              snp_valid = 1'b0;
    logic [ADDR_W-LB-1:0] snp_line = '0;
    logic              ret_ok;
    logic              ret_replay;
    logic [PC_W-1:0]   ret_pc;
    logic              viol_valid;
    logic [PC_W-1:0]   viol_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spec_load_rq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_BITS(LB))
    u_spec_load_rq (.*);

    // kind: 0 quiet, 1 store, 2 line loss
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] off;
        logic [1:0] sz;
        logic       older;
        logic       exp_replay;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 8'h00, 2'd0, 1'b1, 1'b0},  // R2 quiet: no event
        '{2'd1, 8'h08, 2'd0, 1'b1, 1'b1},  // R3 first byte
        '{2'd1, 8'h0B, 2'd0, 1'b1, 1'b1},  // R3 last byte
        '{2'd1, 8'h0C, 2'd2, 1'b1, 1'b0},  // R3 adjacent word
        '{2'd1, 8'h00, 2'd3, 1'b1, 1'b0},  // R3 dword below
        '{2'd1, 8'h0C, 2'd3, 1'b1, 1'b1},  // R3 covering dword
        '{2'd1, 8'h08, 2'd2, 1'b0, 1'b0},  // R4 younger store
        '{2'd2, 8'h00, 2'd0, 1'b1, 1'b1},  // R5 same line
        '{2'd2, 8'h01, 2'd0, 1'b1, 1'b0},  // R5 next line
        '{2'd1, 8'h0A, 2'd1, 1'b1, 1'b1}   // R3 half inside
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] i0, i1;
        logic [PC_W-1:0]  p0, p1;
        @(negedge clk);
        do_reset();

        // R10 reset state
        chk("R10 ready", alloc_ready, 1);
        chk("R10 idx", alloc_idx, 0);
        chk("R10 outputs", {ret_ok, ret_replay, viol_valid}, 0);

        for (int r = 0; r < NROWS; r++) begin
            p0 = 32'h4000 + r * 16;
            p1 = p0 + 4;
            alloc_valid = 1'b1; alloc_pc = p0; i0 = alloc_idx;
            tick();
            alloc_pc = p1; i1 = alloc_idx;
            chk("R1 next slot", i1, i0 + 1'b1);
            tick();
            alloc_valid = 1'b0;
            done_valid = 1'b1; done_idx = i1; done_addr = 32'h2008; done_size = 2'd2;
            tick();
            done_valid = 1'b0;
            if (ROWS[r].kind == 2'd1) begin
                st_valid = 1'b1;
                st_addr  = 32'h2000 + ROWS[r].off;
                st_size  = ROWS[r].sz;
                st_bound = ROWS[r].older ? i1 : i1 + 1'b1;
            end else if (ROWS[r].kind == 2'd2) begin
                snp_valid = 1'b1;
                snp_line  = (ADDR_W-LB)'(32'h80 + ROWS[r].off);
            end
            tick();
            st_valid = 1'b0; snp_valid = 1'b0;
            done_valid = 1'b1; done_idx = i0; done_addr = 32'h8000; done_size = 2'd2;
            // R2: younger load done first does not leave ahead of the head
            chk("R2 hold younger", {ret_ok, ret_replay}, 0);
            tick();
            done_valid = 1'b0;
            chk("R2 not yet", {ret_ok, ret_replay}, 0);
            tick();
            chk("R2 head ok", ret_ok, 1);
            chk("R2 head pc", ret_pc, p0);
            tick();
            // R6: spoiled marker still spoiled several cycles later
            if (ROWS[r].exp_replay) begin
                chk("R7 replay", {ret_replay, ret_ok}, 2'b10);
                chk("R7 viol", viol_valid, 1);
                chk("R7 viol pc", viol_pc, p1);
            end else begin
                chk("R7 quiet", {ret_ok, ret_replay, viol_valid}, 3'b100);
                chk("R7 pc", ret_pc, p1);
            end
            tick();
        end

        // R1 fill to DEPTH and stall
        do_reset();
        alloc_valid = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            alloc_pc = 32'h9000 + k * 4;
            chk("R1 slot", alloc_idx, k[IDX_W-1:0]);
            chk("R1 ready", alloc_ready, 1);
            tick();
        end
        chk("R1 full stalls", alloc_ready, 0);
        tick();
        alloc_valid = 1'b0;
        chk("R1 still full", alloc_ready, 0);

        // R8 event on the retirement edge of the head
        done_valid = 1'b1; done_idx = 0; done_addr = 32'h3000; done_size = 2'd0;
        tick();
        done_valid = 1'b0;
        snp_valid = 1'b1; snp_line = (ADDR_W-LB)'(32'hC0);
        tick();
        snp_valid = 1'b0;
        chk("R8 replay", {ret_replay, ret_ok}, 2'b10);
        chk("R8 viol pc", viol_pc, 32'h9000);

        // R9 flush empties the queue and restarts at the replayed slot
        chk("R9 ready", alloc_ready, 1);
        chk("R9 idx", alloc_idx, 0);
        alloc_valid = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            alloc_pc = 32'hA000 + k * 4;
            chk("R9 refill accepted", alloc_ready, 1);
            tick();
        end
        alloc_valid = 1'b0;
        chk("R9 full again", alloc_ready, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule